// File: doc/BRIEF.md
# ROM Constant Table Reader

This block lets a 4-bit processor core fetch 8-bit constants stored in program ROM. The core first builds a ROM address in a pointer register, one nibble at a time, using three write selects: low, middle and high. It then issues read commands. Each read returns one half of the addressed byte to the accumulator. A low-half read leaves the pointer where it is. A high-half read returns the upper nibble and advances the pointer by one, so a table can be walked with alternating low and high reads.

The ROM is outside the block and is synchronous. The block drives the address and a read strobe in the cycle of the command. The ROM returns the byte on the next cycle, and the selected nibble reaches the accumulator port in that same cycle. The block has two builds, chosen by parameter. The default build addresses a 4K-byte ROM with a 12-bit pointer. The banked build addresses an 8K-byte ROM. In that build the top address bit is tied high, so every constant read lands in the upper 4K bank (1000h to 1FFFh), and the software-visible pointer keeps only 12 bits.

Top module: `romtab_lookup`

## Requirements
- R1: After reset the pointer is zero, `acc_valid` is 0 and `acc_nib` is 0. A read issued first after reset addresses location 0 (1000h in the banked build).
- R2: A write with `wr_sel` = 0 loads pointer bits 3:0 from `wr_nib`. `wr_sel` = 1 loads bits 7:4 and `wr_sel` = 2 loads bits 11:8. The other pointer bits are left unchanged.
- R3: A write with `wr_sel` = 3 changes no pointer bit.
- R4: A low-half read (`rd_lo`) raises `rom_rd` in the same cycle, with `rom_addr` equal to the pointer. In the next cycle `acc_valid` is 1 and `acc_nib` equals `rom_data[3:0]`. The pointer does not change.
- R5: A high-half read (`rd_hi`) raises `rom_rd` in the same cycle, with `rom_addr` equal to the pointer. In the next cycle `acc_valid` is 1 and `acc_nib` equals `rom_data[7:4]`. The pointer then holds its old value plus one.
- R6: Incrementing a pointer of FFFh gives 000h. The wrap stays within the 12 writable bits.
- R7: In the banked build (`BANK_EN` = 1), `rom_addr` is `{1'b1, pointer}`. Every read therefore falls in 1000h to 1FFFh, including the read that follows a wrap.
- R8: When `rd_lo` and `rd_hi` are both high, the command is treated as a high-half read.
- R9: When a write and `rd_hi` occur in the same cycle, the read uses the pointer value from before the write. The write is applied and no increment happens.
- R10: In a cycle that follows a cycle with no read command, `acc_valid` is 0 and `acc_nib` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Pointer nibble write strobe |
| wr_sel | input | 2 | Pointer nibble select: 0 low, 1 middle, 2 high, 3 none |
| wr_nib | input | 4 | Nibble to write into the pointer |
| rd_lo | input | 1 | Read the low half of ROM[pointer] |
| rd_hi | input | 1 | Read the high half of ROM[pointer], then advance the pointer |
| rom_rd | output | 1 | ROM read strobe |
| rom_addr | output | 12 + BANK_EN | ROM byte address |
| rom_data | input | 8 | ROM byte, valid one cycle after `rom_rd` |
| acc_nib | output | 4 | Selected nibble for the accumulator |
| acc_valid | output | 1 | `acc_nib` carries a read result |

## Verification
The assertions take two things for granted about the inputs. First, `rom_data` comes from a memory that answers exactly one cycle after `rom_rd`. Second, reads and writes may overlap freely, so the pointer checks are written to cover the case where both occur in one cycle. The bench meets the first assumption by modelling the ROM as a registered function of `rom_addr`, and it drives both builds from one stimulus stream. That stream includes overlapped read and write commands, the unused select code, and a walk across the FFFh boundary. A behavioural model predicts the address, the strobe and the accumulator nibble on every clock.

// File: rtl/romtab_pkg.sv
package romtab_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_MID  = 2'd1,
    SEL_HI   = 2'd2,
    SEL_NONE = 2'd3
  } nib_sel_e;
endpackage

// File: rtl/romtab_ptr.sv
module romtab_ptr #(
  parameter int NIB_W    = 4,
  parameter int PTR_NIBS = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [1:0]                wr_sel,
  input  logic [NIB_W-1:0]          wr_nib,
  input  logic                      inc,
  output logic [NIB_W*PTR_NIBS-1:0] ptr_q
);
  localparam int PTR_W = NIB_W * PTR_NIBS;

  logic [PTR_W-1:0] ptr_nxt;
  assign ptr_nxt = ptr_q + PTR_W'(1);

  // Each nibble is its own register slice; any write suppresses the increment.
  for (genvar g = 0; g < PTR_NIBS; g++) begin : g_nib
    always_ff @(posedge clk) begin
      if (rst)
        ptr_q[g*NIB_W +: NIB_W] <= '0;
      else if (wr_en && (int'(wr_sel) == g))
        ptr_q[g*NIB_W +: NIB_W] <= wr_nib;
      else if (inc && !wr_en)
        ptr_q[g*NIB_W +: NIB_W] <= ptr_nxt[g*NIB_W +: NIB_W];
    end
  end

  p_incr_wraps_r6: assert property (@(posedge clk) disable iff (rst)
    (inc && !wr_en) |=> (ptr_q - $past(ptr_q)) == PTR_W'(1));

  p_idle_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (!inc && !wr_en) |=> $stable(ptr_q));

  p_bad_sel_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd3) |=> $stable(ptr_q));

  p_write_beats_inc_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && inc && wr_sel != 2'd0) |=> ptr_q[NIB_W-1:0] == $past(ptr_q[NIB_W-1:0]));
endmodule

// File: rtl/romtab_addr.sv
module romtab_addr #(
  parameter int PTR_W   = 12,
  parameter int BANK_EN = 0
) (
  input  logic [PTR_W-1:0]         ptr,
  output logic [PTR_W+BANK_EN-1:0] rom_addr
);
  if (BANK_EN != 0) begin : g_banked
    assign rom_addr = {1'b1, ptr};
  end else begin : g_flat
    assign rom_addr = ptr;
  end
endmodule

// File: rtl/romtab_rdpipe.sv
module romtab_rdpipe #(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_lo,
  input  logic               rd_hi,
  input  logic [2*NIB_W-1:0] rom_data,
  output logic               rom_rd,
  output logic               inc,
  output logic [NIB_W-1:0]   acc_nib,
  output logic               acc_valid
);
  logic hi_q;

  assign rom_rd = rd_lo | rd_hi;
  assign inc    = rd_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid <= 1'b0;
      hi_q      <= 1'b0;
    end else begin
      acc_valid <= rom_rd;
      hi_q      <= rd_hi;
    end
  end

  always_comb begin
    if (!acc_valid)
      acc_nib = '0;
    else if (hi_q)
      acc_nib = rom_data[2*NIB_W-1:NIB_W];
    else
      acc_nib = rom_data[NIB_W-1:0];
  end

  p_valid_after_rd_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_lo || rd_hi) |=> acc_valid);

  p_quiet_after_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !(rd_lo || rd_hi) |=> (!acc_valid && acc_nib == '0));

  p_hi_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && rd_hi) |=> acc_nib == rom_data[2*NIB_W-1:NIB_W]);
endmodule

// File: rtl/romtab_lookup.sv
module romtab_lookup #(
  parameter int PTR_NIBS = 3,
  parameter int BANK_EN  = 0
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       wr_en,
  input  logic [1:0]                                 wr_sel,
  input  logic [romtab_pkg::NIB_W-1:0]               wr_nib,
  input  logic                                       rd_lo,
  input  logic                                       rd_hi,
  output logic                                       rom_rd,
  output logic [romtab_pkg::NIB_W*PTR_NIBS+BANK_EN-1:0] rom_addr,
  input  logic [2*romtab_pkg::NIB_W-1:0]             rom_data,
  output logic [romtab_pkg::NIB_W-1:0]               acc_nib,
  output logic                                       acc_valid
);
  localparam int NIB_W = romtab_pkg::NIB_W;
  localparam int PTR_W = NIB_W * PTR_NIBS;

  logic [PTR_W-1:0] ptr;
  logic             inc;

  romtab_ptr #(.NIB_W(NIB_W), .PTR_NIBS(PTR_NIBS)) ptr_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_nib(wr_nib), .inc(inc), .ptr_q(ptr)
  );

  romtab_addr #(.PTR_W(PTR_W), .BANK_EN(BANK_EN)) addr_i (
    .ptr(ptr), .rom_addr(rom_addr)
  );

  romtab_rdpipe #(.NIB_W(NIB_W)) rd_i (
    .clk(clk), .rst(rst), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .rom_data(rom_data), .rom_rd(rom_rd), .inc(inc),
    .acc_nib(acc_nib), .acc_valid(acc_valid)
  );

  if (BANK_EN != 0) begin : g_bank_chk
    p_bank_one_r7: assert property (@(posedge clk) disable iff (rst)
      (rd_hi && !wr_en) |=> rom_addr[PTR_W] == $past(rom_addr[PTR_W]));
  end
endmodule

// File: tb/romtab_lookup_tb.sv
module romtab_lookup_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [3:0] wr_nib = 4'd0;
  logic rd_lo = 1'b0;
  logic rd_hi = 1'b0;

  logic        rom_rd_a, rom_rd_b;
  logic [11:0] rom_addr_a;
  logic [12:0] rom_addr_b;
  logic [7:0]  rom_dat_a = 8'd0, rom_dat_b = 8'd0;
  logic [3:0]  acc_a, acc_b;
  logic        val_a, val_b;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  int mptr  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] romfn(int a);
    return 8'((a * 29) ^ (a >> 3) ^ 8'h5A);
  endfunction

  always_ff @(posedge clk) begin
    if (rom_rd_a) rom_dat_a <= romfn(int'(rom_addr_a));
    if (rom_rd_b) rom_dat_b <= romfn(int'(rom_addr_b));
  end

  romtab_lookup #(.PTR_NIBS(3), .BANK_EN(0)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_nib(wr_nib),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .rom_rd(rom_rd_a), .rom_addr(rom_addr_a),
    .rom_data(rom_dat_a), .acc_nib(acc_a), .acc_valid(val_a)
  );

  romtab_lookup #(.PTR_NIBS(3), .BANK_EN(1)) dut_b (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_nib(wr_nib),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .rom_rd(rom_rd_b), .rom_addr(rom_addr_b),
    .rom_data(rom_dat_b), .acc_nib(acc_b), .acc_valid(val_b)
  );

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock of stimulus with model update and comparison.
  task automatic step(bit wr, logic [1:0] sel, logic [3:0] nib, bit lo, bit hi, string tag);
    int  eaddr;
    bit  ev, eh;
    int  en_a, en_b;
    wr_en = wr; wr_sel = sel; wr_nib = nib; rd_lo = lo; rd_hi = hi;
    #1;
    ev = lo | hi;
    chk({tag, " rom_rd flat"},   int'(rom_rd_a), int'(ev));
    chk({tag, " rom_rd banked"}, int'(rom_rd_b), int'(ev));
    if (ev) begin
      chk({tag, " addr flat"},        int'(rom_addr_a), mptr);
      chk({tag, " addr banked R7"},   int'(rom_addr_b), mptr | 32'h1000);
    end
    @(posedge clk);
    eh = hi;
    eaddr = mptr;
    if (wr) begin
      if (sel == 2'd0) mptr = (mptr & 32'hFF0) | int'(nib);
      else if (sel == 2'd1) mptr = (mptr & 32'hF0F) | (int'(nib) << 4);
      else if (sel == 2'd2) mptr = (mptr & 32'h0FF) | (int'(nib) << 8);
    end else if (hi) begin
      mptr = (mptr + 1) & 32'hFFF;
    end
    @(negedge clk);
    en_a = !ev ? 0 : (eh ? int'(romfn(eaddr)) >> 4 : int'(romfn(eaddr)) & 15);
    en_b = !ev ? 0 : (eh ? int'(romfn(eaddr | 32'h1000)) >> 4
                         : int'(romfn(eaddr | 32'h1000)) & 15);
    chk({tag, " valid flat"},   int'(val_a), int'(ev));
    chk({tag, " valid banked"}, int'(val_b), int'(ev));
    chk({tag, " nib flat"},     int'(acc_a), en_a);
    chk({tag, " nib banked"},   int'(acc_b), en_b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset valid", int'(val_a), 0);
    chk("R1 reset nib", int'(acc_b), 0);
    step(0, 2'd0, 4'd0, 1, 0, "R1 first read at zero");
    step(1, 2'd0, 4'hA, 0, 0, "R2 low write");
    step(1, 2'd1, 4'h3, 0, 0, "R2 mid write");
    step(1, 2'd2, 4'h7, 0, 0, "R2 high write");
    step(0, 2'd0, 4'd0, 1, 0, "R4 low read");
    step(0, 2'd0, 4'd0, 1, 0, "R4 low read repeat");
    step(0, 2'd0, 4'd0, 0, 1, "R5 high read");
    step(0, 2'd0, 4'd0, 1, 0, "R5 advanced pointer");
    step(0, 2'd0, 4'd0, 0, 0, "R10 idle");
    step(1, 2'd3, 4'hF, 0, 0, "R3 unused select");
    step(0, 2'd0, 4'd0, 1, 0, "R3 pointer intact");
    step(1, 2'd2, 4'hF, 0, 0, "R6 setup hi");
    step(1, 2'd1, 4'hF, 0, 0, "R6 setup mid");
    step(1, 2'd0, 4'hE, 0, 0, "R6 setup lo");
    step(0, 2'd0, 4'd0, 0, 1, "R6 read FFE");
    step(0, 2'd0, 4'd0, 0, 1, "R6 read FFF");
    step(0, 2'd0, 4'd0, 1, 0, "R6 R7 wrapped read");
    step(0, 2'd0, 4'd0, 1, 1, "R8 both reads");
    step(0, 2'd0, 4'd0, 1, 0, "R8 pointer advanced");
    step(1, 2'd0, 4'h5, 0, 1, "R9 write with high read");
    step(1, 2'd2, 4'h9, 0, 1, "R9 high nibble write with read");
    step(0, 2'd0, 4'd0, 1, 0, "R9 pointer after overlap");
    for (int i = 0; i < 40; i++) begin
      step((i % 5) == 0, 2'(i % 4), 4'(i * 7), (i % 3) == 1, (i % 2) == 0, "R5 R4 mixed walk");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule